// File: doc/BRIEF.md
# Keyed Control and Interrupt Register Bank

This block is a small byte-wide register bank. It holds two control registers that accept changes only when a fixed key is present in the upper bits of the same written byte. It also holds an interrupt status register and an interrupt mask register. The first keyed register holds storage protect bits, and the bank uses them to flag storage writes that hit a protected region. The second keyed register takes a backup command and presents it as a request until the storage side reports completion.

Status bits are set by single-cycle event pulses and cleared by writing ones. An active-low, level-sensitive interrupt output stays low while any unmasked status bit is set. Reads are combinational from the address. Writes take effect at the clock edge where `wr_en_i` is sampled high.

Top module: `keyed_ctrl_regs`

## Requirements
- R1: After reset every register reads 0x00, `irq_no` is high and `bkp_req_o` is 0.
- R2: The address map is: 0 holds the protect register, 1 holds the backup command, 2 holds the interrupt status and 3 holds the interrupt mask.
- R3: A write to the protect register whose bits 7:3 equal 0xB loads bit 0 (protect every region) and bit 1 (protect only the board-info region) from the written byte. For example, 0x59 reads back as 0x01. Bits 7:2 always read 0.
- R4: A write to the protect register with any other value in bits 7:3 leaves its contents unchanged.
- R5: A pulse on `store_wr_i` sets status bit 2 in either of two cases: protect bit 0 is set, or protect bit 1 is set while `store_info_i` is high. A storage write that no protect bit covers leaves status unchanged.
- R6: A write of 0xA1, 0xA2 or 0xA3 to the idle command register stores the byte. It then raises `bkp_req_o` bit 0 (save to user area), bit 1 (load from user area) or bit 2 (load from factory area), respectively. In every other case the write is dropped: a wrong upper nibble, or a lower-nibble code other than 1, 2 or 3.
- R7: While a command is pending, further command writes are dropped.
- R8: A `bkp_done_i` pulse while a command is pending clears the command register to 0x00 and drops `bkp_req_o` at the same edge.
- R9: Each `evt_i` pulse sets its status bit. Writing a 1 to a status bit clears it, but a set in the same cycle wins. Bit 3 is reserved in both status and mask and always reads 0. Status bit layout: 0 button, 1 key erased, 2 protect violation, 4 GPIO change, 5 tamper, 6 boot watchdog timeout, 7 switch hold.
- R10: `irq_no` is low exactly while some status bit and its mask bit are both set. It returns high when the bit is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| store_wr_i | input | 1 | Pulse: a storage write is being attempted |
| store_info_i | input | 1 | The attempted write targets the board-info region |
| evt_i | input | 8 | Single-cycle event pulses, one per status bit |
| bkp_done_i | input | 1 | Pulse: the pending backup operation has completed |
| bkp_req_o | output | 3 | One-hot request: save, user load, factory load |
| irq_no | output | 1 | Interrupt, active low, level-sensitive |

## Verification
Every register write, event pulse, storage write and completion pulse takes effect at the first rising edge that samples it. Read data, `bkp_req_o` and `irq_no` follow from registered state without further delay. Because of this, each result is due one edge after its stimulus. The bench therefore drives inputs on the falling edge, lets exactly one rising edge pass, and samples at the next falling edge. A dropped write or command is confirmed by reading the register back before any other stimulus is applied.

// File: rtl/keyed_regs_pkg.sv
package keyed_regs_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 2;
  localparam int unsigned NREQ    = 3;

  localparam logic [AW-1:0] A_PROT = 2'd0;
  localparam logic [AW-1:0] A_CMD  = 2'd1;
  localparam logic [AW-1:0] A_STAT = 2'd2;
  localparam logic [AW-1:0] A_MASK = 2'd3;

  localparam logic [4:0] PROT_KEY = 5'h0B;
  localparam logic [3:0] CMD_KEY  = 4'hA;

  localparam int unsigned VIOL_BIT = 2;
  localparam logic [DW-1:0] RSVD_BITS = 8'h08;

  typedef enum logic [3:0] {
    BK_IDLE   = 4'd0,
    BK_SAVE   = 4'd1,
    BK_ULOAD  = 4'd2,
    BK_FLOAD  = 4'd3
  } bkp_cmd_e;
endpackage

// File: rtl/prot_reg.sv
module prot_reg
  import keyed_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [4:0] key_i,
  input  logic [1:0] bits_i,
  input  logic       store_wr_i,
  input  logic       store_info_i,
  output logic [1:0] prot_o,
  output logic       viol_o
);
  logic [1:0] prot_q;
  logic       key_ok;

  assign key_ok = (key_i == PROT_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            prot_q <= '0;
    else if (wr_i && key_ok) prot_q <= bits_i;
  end

  // bit0 covers everything, bit1 only the board-info region
  assign viol_o = store_wr_i & (prot_q[0] | (prot_q[1] & store_info_i));
  assign prot_o = prot_q;

  a_r4_bad_key_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !key_ok) |=> $stable(prot_q));
endmodule

// File: rtl/bkp_cmd_reg.sv
module bkp_cmd_reg
  import keyed_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       done_i,
  output bkp_cmd_e   cmd_o
);
  bkp_cmd_e cmd_q;
  logic     busy;
  logic     code_ok;

  assign busy    = (cmd_q != BK_IDLE);
  assign code_ok = (wdata_i[3:0] == BK_SAVE) || (wdata_i[3:0] == BK_ULOAD) ||
                   (wdata_i[3:0] == BK_FLOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= BK_IDLE;
    else if (busy) begin
      if (done_i) cmd_q <= BK_IDLE;
    end else if (wr_i && wdata_i[7:4] == CMD_KEY && code_ok) begin
      cmd_q <= bkp_cmd_e'(wdata_i[3:0]);
    end
  end

  assign cmd_o = cmd_q;

  a_r7_busy_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_i) |=> $stable(cmd_q));
  a_r8_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && done_i) |=> (cmd_q == BK_IDLE));
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         wr_stat_i,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         irq_no
);
  logic [W-1:0] stat_q, mask_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RSVD[i]) begin : g_rsvd
      assign stat_q[i] = 1'b0;
      assign mask_q[i] = 1'b0;
    end else begin : g_live
      logic s_q, m_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s_q <= 1'b0;
          m_q <= 1'b0;
        end else begin
          // set beats write-one-to-clear
          if (evt_i[i])                    s_q <= 1'b1;
          else if (wr_stat_i && wdata_i[i]) s_q <= 1'b0;
          if (wr_mask_i) m_q <= wdata_i[i];
        end
      end
      assign stat_q[i] = s_q;
      assign mask_q[i] = m_q;

      a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[i] |=> stat_q[i]);
    end
  end

  assign irq_no = ~|(stat_q & mask_q);
  assign stat_o = stat_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/keyed_ctrl_regs.sv
module keyed_ctrl_regs
  import keyed_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          store_wr_i,
  input  logic          store_info_i,
  input  logic [DW-1:0] evt_i,
  input  logic          bkp_done_i,
  output logic [NREQ-1:0] bkp_req_o,
  output logic          irq_no
);
  logic [1:0]    prot;
  logic          viol;
  bkp_cmd_e      cmd;
  logic [DW-1:0] stat, mask, evt_all;

  prot_reg u_prot (
    .clk_i, .rst_ni,
    .wr_i        (wr_en_i && addr_i == A_PROT),
    .key_i       (wdata_i[7:3]),
    .bits_i      (wdata_i[1:0]),
    .store_wr_i,
    .store_info_i,
    .prot_o      (prot),
    .viol_o      (viol)
  );

  bkp_cmd_reg u_bkp (
    .clk_i, .rst_ni,
    .wr_i    (wr_en_i && addr_i == A_CMD),
    .wdata_i,
    .done_i  (bkp_done_i),
    .cmd_o   (cmd)
  );

  always_comb begin
    evt_all = evt_i;
    evt_all[VIOL_BIT] = evt_i[VIOL_BIT] | viol;
  end

  irq_bank #(.W(DW), .RSVD(RSVD_BITS)) u_irq (
    .clk_i, .rst_ni,
    .evt_i     (evt_all),
    .wr_stat_i (wr_en_i && addr_i == A_STAT),
    .wr_mask_i (wr_en_i && addr_i == A_MASK),
    .wdata_i,
    .stat_o    (stat),
    .mask_o    (mask),
    .irq_no
  );

  for (genvar k = 0; k < NREQ; k++) begin : g_req
    assign bkp_req_o[k] = (cmd == bkp_cmd_e'(k + 1));
  end

  always_comb begin
    case (addr_i)
      A_PROT:  rdata_o = {6'b0, prot};
      A_CMD:   rdata_o = (cmd == BK_IDLE) ? 8'h00 : {CMD_KEY, 4'(cmd)};
      A_STAT:  rdata_o = stat;
      default: rdata_o = mask;
    endcase
  end

  a_r5_viol_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol |=> stat[VIOL_BIT]);
  a_r6_req_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bkp_req_o));
endmodule

// File: tb/keyed_ctrl_regs_tb.sv
module keyed_ctrl_regs_tb;
  logic       clk = 0, rst_ni = 0;
  logic       wr_en = 0, store_wr = 0, store_info = 0, done = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, evt = 0, rdata;
  logic [2:0] req;
  logic       irq_n;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  keyed_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .store_wr_i(store_wr), .store_info_i(store_info),
    .evt_i(evt), .bkp_done_i(done), .bkp_req_o(req), .irq_no(irq_n)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    wr_en = 0; store_wr = 0; done = 0; evt = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; step();
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic rchk(string tag, logic [1:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d); chk(tag, d, exp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) rchk("R1 R2 reset reg", 2'(a), 8'h00);
    chk("R1 irq_no reset", {7'b0, irq_n}, 8'h01);
    chk("R1 req reset", {5'b0, req}, 8'h00);
  endtask

  task automatic t_prot();
    wr(0, 8'h59); rchk("R3 protect-all key", 0, 8'h01);
    wr(0, 8'h5A); rchk("R3 protect-info key", 0, 8'h02);
    wr(0, 8'h12); rchk("R4 wrong key ignored", 0, 8'h02);
    wr(0, 8'h03); rchk("R4 zero key ignored", 0, 8'h02);
    wr(0, 8'h5F); rchk("R3 bit2 reads 0", 0, 8'h03);
    wr(0, 8'h58); rchk("R3 clear with key", 0, 8'h00);
  endtask

  task automatic t_viol();
    store_wr = 1; store_info = 1; step();
    rchk("R5 unprotected write", 2, 8'h00);
    wr(0, 8'h5A);
    store_wr = 1; store_info = 0; step();
    rchk("R5 info prot, other region", 2, 8'h00);
    store_wr = 1; store_info = 1; step();
    rchk("R5 info prot hit", 2, 8'h04);
    wr(2, 8'h04); rchk("R9 w1c violation", 2, 8'h00);
    wr(0, 8'h59);
    store_wr = 1; store_info = 0; step();
    rchk("R5 all prot hit", 2, 8'h04);
    wr(2, 8'h04); wr(0, 8'h58); store_info = 0;
  endtask

  task automatic t_bkp();
    wr(1, 8'hA1);
    rchk("R6 save stored", 1, 8'hA1);
    chk("R6 save req", {5'b0, req}, 8'h01);
    wr(1, 8'hA2);
    rchk("R7 busy drop", 1, 8'hA1);
    done = 1; step();
    rchk("R8 done clears", 1, 8'h00);
    chk("R8 req dropped", {5'b0, req}, 8'h00);
    wr(1, 8'hA2); chk("R6 user load req", {5'b0, req}, 8'h02);
    done = 1; step();
    wr(1, 8'hA3); chk("R6 factory load req", {5'b0, req}, 8'h04);
    rchk("R6 factory stored", 1, 8'hA3);
    done = 1; step();
    wr(1, 8'hB2); rchk("R6 wrong key dropped", 1, 8'h00);
    wr(1, 8'hA5); rchk("R6 unknown code dropped", 1, 8'h00);
    wr(1, 8'hA0); chk("R6 code 0 no req", {5'b0, req}, 8'h00);
  endtask

  task automatic t_irq();
    evt = 8'h01; step();
    rchk("R9 event sets", 2, 8'h01);
    chk("R10 masked no irq", {7'b0, irq_n}, 8'h01);
    wr(3, 8'hFF); rchk("R9 mask rsvd 0", 3, 8'hF7);
    chk("R10 irq low", {7'b0, irq_n}, 8'h00);
    evt = 8'h08; step(); rchk("R9 rsvd status 0", 2, 8'h01);
    evt = 8'h01; wr_en = 1; addr = 2; wdata = 8'h01; step();
    rchk("R9 set beats clear", 2, 8'h01);
    wr(2, 8'h01); rchk("R9 w1c", 2, 8'h00);
    chk("R10 irq released", {7'b0, irq_n}, 8'h01);
    evt = 8'h80; step();
    chk("R10 irq hold", {7'b0, irq_n}, 8'h00);
    step(); chk("R10 level stays", {7'b0, irq_n}, 8'h00);
    wr(3, 8'h00); chk("R10 mask releases", {7'b0, irq_n}, 8'h01);
    rchk("R9 status kept", 2, 8'h80);
  endtask

  initial begin
    #20000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_ni = 1; @(negedge clk);
    t_reset(); t_prot(); t_viol(); t_bkp(); t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule